// File: doc/BRIEF.md
# Nibble-Serial Flash Read Target

This block is the target-side engine of a 4-bit multiplexed firmware-memory bus. The host marks a transaction with an active-low frame strobe. On the clocks after the strobe it sends a device select nibble, a 28-bit address as seven nibbles, and a size nibble. It then hands the bus over. The target answers with a ready-sync nibble and one data byte, drives the bus high for one clock, and lets go. A full read takes 17 clocks, counted from the last clock with the strobe low (clock 1).

The bus is split at the pins into an observed value (`bus_i`), a driven value (`bus_o`) and an output enable (`bus_oe`); the pad combines them. The storage array sits outside the block behind a synchronous read port. The block pulses `mem_req` with the assembled address, and the array returns the byte on `mem_rdata` one clock later. The block's own strap inputs pick which select value it answers to.

Top module: `nsr_read_target`

## Requirements
- R1: While `rst_n` is low, and after its release until a read is decoded, `bus_oe` and `mem_req` stay low.
- R2: The nibble seen on the last clock with `frame_n` low is the start field (clock 1). Earlier nibbles under the same low strobe are discarded. A start field of 4'b1101 begins a read whose select nibble comes on the next clock (clock 2).
- R3: If the select nibble on clock 2 differs from `id_strap`, the rest of the frame is ignored: `bus_oe` and `mem_req` stay low.
- R4: Clocks 3 to 9 carry the address. The clock 3 nibble becomes bits 27:24 and the clock 9 nibble becomes bits 3:0 of `mem_addr`.
- R5: The size nibble on clock 10 must be 4'b0000. Any other value abandons the read with no drive and no request.
- R6: A start field other than 4'b1101 is ignored: no drive and no request follow.
- R7: The host turnaround is clock 11. On clock 12 the target enables its drivers with 4'b1111, and on clock 13 it drives the ready-sync value 4'b0000.
- R8: The data byte is driven as bits 3:0 on clock 14, then bits 7:4 on clock 15.
- R9: On clock 16 the target drives 4'b1111. From clock 17 on `bus_oe` is low, so the enable is high exactly on clocks 12 to 16.
- R10: `mem_req` is high for the single clock 12, with `mem_addr` holding the address. The byte on `mem_rdata` one clock later is the byte returned.
- R11: When `frame_n` is sampled low in the middle of a read, `bus_oe` is low from the next clock. That clock starts a new start-field detection, so a following well-formed read is served normally.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| frame_n | input | 1 | Active-low frame strobe from the host |
| bus_i | input | 4 | Nibble observed on the shared bus |
| id_strap | input | 4 | Device select value this target answers to |
| bus_o | output | 4 | Nibble driven when the enable is high |
| bus_oe | output | 1 | Bus output enable |
| mem_req | output | 1 | One-clock read request to the array |
| mem_addr | output | 28 | Assembled read address |
| mem_rdata | input | 8 | Byte from the array, one clock after the request |

## Verification
Directed reads cover these cases:
- a clean read;
- addresses of all zeros and all ones, which show whether the nibble order is right;
- a select mismatch, a wrong start code and a nonzero size, which show that each gate alone suppresses the response;
- several start nibbles under one strobe, where only the last decides;
- aborts during the address and during data, where the enable must drop and a following read must still succeed.

A seeded random mix then varies the number of start nibbles, the select match, the size, the address and the abort point. Noise on the bus during the target-owned clocks shows that the block ignores the bus there. Every response is compared clock by clock, with the request address checked against a byte function kept in the bench.

// File: rtl/nsr_pkg.sv
package nsr_pkg;

  typedef enum logic [3:0] {
    ST_IDLE,
    ST_START,
    ST_ADDR,
    ST_SIZE,
    ST_TAR0,
    ST_TAR1,
    ST_SYNC,
    ST_DLO,
    ST_DHI,
    ST_TEND
  } nsr_state_e;

endpackage

// File: rtl/nsr_ctrl.sv
module nsr_ctrl
  import nsr_pkg::*;
#(
  parameter int          NIB_W      = 4,
  parameter int          ADDR_NIBS  = 7,
  parameter logic [3:0]  START_CODE = 4'b1101,
  parameter logic [3:0]  SIZE_ONE   = 4'b0000
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             frame_n,
  input  logic [NIB_W-1:0] bus_i,
  input  logic [NIB_W-1:0] id_strap,
  output nsr_state_e       state,
  output logic             shift_en,
  output logic             mem_req
);

  localparam int              CNT_W    = (ADDR_NIBS > 1) ? $clog2(ADDR_NIBS) : 1;
  localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(ADDR_NIBS - 1);

  nsr_state_e       state_q, state_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             start_ok_q, start_ok_d;

  always_comb begin
    state_d    = state_q;
    cnt_d      = cnt_q;
    start_ok_d = start_ok_q;
    if (!frame_n) begin
      state_d    = ST_START;
      start_ok_d = (bus_i == NIB_W'(START_CODE));
    end else begin
      case (state_q)
        ST_IDLE:  state_d = ST_IDLE;
        ST_START: begin
          cnt_d   = '0;
          state_d = (start_ok_q && (bus_i == id_strap)) ? ST_ADDR : ST_IDLE;
        end
        ST_ADDR: begin
          if (cnt_q == CNT_LAST) state_d = ST_SIZE;
          else                   cnt_d   = cnt_q + 1'b1;
        end
        ST_SIZE:  state_d = (bus_i == NIB_W'(SIZE_ONE)) ? ST_TAR0 : ST_IDLE;
        ST_TAR0:  state_d = ST_TAR1;
        ST_TAR1:  state_d = ST_SYNC;
        ST_SYNC:  state_d = ST_DLO;
        ST_DLO:   state_d = ST_DHI;
        ST_DHI:   state_d = ST_TEND;
        ST_TEND:  state_d = ST_IDLE;
        default:  state_d = ST_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q    <= ST_IDLE;
      cnt_q      <= '0;
      start_ok_q <= 1'b0;
    end else begin
      state_q    <= state_d;
      cnt_q      <= cnt_d;
      start_ok_q <= start_ok_d;
    end
  end

  assign state    = state_q;
  assign shift_en = frame_n && (state_q == ST_ADDR);
  assign mem_req  = frame_n && (state_q == ST_TAR1);

  // R3: a select mismatch drops the frame
  a_r3_id_gate: assert property (@(posedge clk) disable iff (!rst_n)
    (frame_n && state_q == ST_START && bus_i != id_strap) |=> (state_q == ST_IDLE));

  // R6: a wrong start field drops the frame
  a_r6_bad_start: assert property (@(posedge clk) disable iff (!rst_n)
    (frame_n && state_q == ST_START && !start_ok_q) |=> (state_q == ST_IDLE));

  // R5: only the one-byte size continues
  a_r5_size_gate: assert property (@(posedge clk) disable iff (!rst_n)
    (frame_n && state_q == ST_SIZE && bus_i != NIB_W'(SIZE_ONE)) |=> (state_q == ST_IDLE));

  // R11: a low strobe always restarts start detection
  a_r11_abort: assert property (@(posedge clk) disable iff (!rst_n)
    (!frame_n) |=> (state_q == ST_START));

endmodule

// File: rtl/nsr_addr_asm.sv
module nsr_addr_asm #(
  parameter int NIB_W     = 4,
  parameter int ADDR_NIBS = 7
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       shift_en,
  input  logic [NIB_W-1:0]           nib,
  output logic [NIB_W*ADDR_NIBS-1:0] addr
);

  localparam int ADDR_W = NIB_W * ADDR_NIBS;

  logic [ADDR_W-1:0] addr_q, addr_d;

  generate
    if (ADDR_NIBS > 1) begin : g_multi
      always_comb begin
        addr_d = addr_q;
        if (shift_en) addr_d = {addr_q[ADDR_W-NIB_W-1:0], nib};
      end
    end else begin : g_single
      always_comb begin
        addr_d = addr_q;
        if (shift_en) addr_d = nib;
      end
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) addr_q <= '0;
    else        addr_q <= addr_d;
  end

  assign addr = addr_q;

  // R4: each address clock lands its nibble in the low position
  a_r4_shift_in: assert property (@(posedge clk) disable iff (!rst_n)
    shift_en |=> (addr_q[NIB_W-1:0] == $past(nib)));

endmodule

// File: rtl/nsr_bus_drive.sv
module nsr_bus_drive
  import nsr_pkg::*;
#(
  parameter int NIB_W = 4
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  nsr_state_e           state,
  input  logic [2*NIB_W-1:0]   mem_rdata,
  output logic [NIB_W-1:0]     bus_o,
  output logic                 bus_oe
);

  localparam int DATA_W = 2 * NIB_W;

  logic [DATA_W-1:0] data_q, data_d;

  always_comb begin
    data_d = data_q;
    if (state == ST_SYNC) data_d = mem_rdata;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) data_q <= '0;
    else        data_q <= data_d;
  end

  always_comb begin
    bus_oe = 1'b1;
    case (state)
      ST_TAR1: bus_o = '1;
      ST_SYNC: bus_o = '0;
      ST_DLO:  bus_o = data_q[NIB_W-1:0];
      ST_DHI:  bus_o = data_q[DATA_W-1:NIB_W];
      ST_TEND: bus_o = '1;
      default: begin
        bus_o  = '0;
        bus_oe = 1'b0;
      end
    endcase
  end

  // R7: ownership always begins with an all-ones nibble
  a_r7_own_ones: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(bus_oe) |-> (bus_o == {NIB_W{1'b1}}));

  // R9: the bus is released after the closing nibble
  a_r9_release: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_TEND) |=> !bus_oe);

  // R10: the byte is taken one clock after the request clock
  a_r10_capture: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_SYNC) |=> (data_q == $past(mem_rdata)));

endmodule

// File: rtl/nsr_read_target.sv
module nsr_read_target
  import nsr_pkg::*;
#(
  parameter int NIB_W     = 4,
  parameter int ADDR_NIBS = 7
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       frame_n,
  input  logic [NIB_W-1:0]           bus_i,
  input  logic [NIB_W-1:0]           id_strap,
  output logic [NIB_W-1:0]           bus_o,
  output logic                       bus_oe,
  output logic                       mem_req,
  output logic [NIB_W*ADDR_NIBS-1:0] mem_addr,
  input  logic [2*NIB_W-1:0]         mem_rdata
);

  logic [1:0] rst_sync_q;
  logic       rst_int_n;
  nsr_state_e state;
  logic       shift_en;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_int_n = rst_sync_q[1];

  nsr_ctrl #(
    .NIB_W     (NIB_W),
    .ADDR_NIBS (ADDR_NIBS)
  ) u_ctrl (
    .clk      (clk),
    .rst_n    (rst_int_n),
    .frame_n  (frame_n),
    .bus_i    (bus_i),
    .id_strap (id_strap),
    .state    (state),
    .shift_en (shift_en),
    .mem_req  (mem_req)
  );

  nsr_addr_asm #(
    .NIB_W     (NIB_W),
    .ADDR_NIBS (ADDR_NIBS)
  ) u_addr (
    .clk      (clk),
    .rst_n    (rst_int_n),
    .shift_en (shift_en),
    .nib      (bus_i),
    .addr     (mem_addr)
  );

  nsr_bus_drive #(
    .NIB_W (NIB_W)
  ) u_drive (
    .clk       (clk),
    .rst_n     (rst_int_n),
    .state     (state),
    .mem_rdata (mem_rdata),
    .bus_o     (bus_o),
    .bus_oe    (bus_oe)
  );

  // R1: quiet while reset is held
  a_r1_reset_quiet: assert property (@(posedge clk)
    (!rst_n) |-> (!bus_oe && !mem_req));

  // R10: the request is a single-clock pulse
  a_r10_req_pulse: assert property (@(posedge clk) disable iff (!rst_int_n)
    mem_req |=> !mem_req);

endmodule

// File: tb/nsr_read_target_tb.sv
module nsr_read_target_tb;

  localparam logic [3:0] MY_ID = 4'hA;

  logic        clk;
  logic        rst_n;
  logic        frame_n;
  logic [3:0]  bus_i;
  logic [3:0]  id_strap;
  logic [3:0]  bus_o;
  logic        bus_oe;
  logic        mem_req;
  logic [27:0] mem_addr;
  logic [7:0]  mem_rdata;

  int          checks;
  int          errors;
  int          req_cnt;
  logic [27:0] last_addr;
  bit          done;

  nsr_read_target u_dut (
    .clk       (clk),
    .rst_n     (rst_n),
    .frame_n   (frame_n),
    .bus_i     (bus_i),
    .id_strap  (id_strap),
    .bus_o     (bus_o),
    .bus_oe    (bus_oe),
    .mem_req   (mem_req),
    .mem_addr  (mem_addr),
    .mem_rdata (mem_rdata)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  function automatic logic [7:0] mem_fn(input logic [27:0] a);
    return a[7:0] ^ a[15:8] ^ {a[27:24], a[19:16]} ^ 8'h5A;
  endfunction

  // array model: one clock of read latency
  always @(posedge clk) begin
    if (mem_req) begin
      mem_rdata <= mem_fn(mem_addr);
      last_addr <= mem_addr;
      req_cnt   <= req_cnt + 1;
    end
  end

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h at %0t", req, act, exp, $time);
    end
  endtask

  // one frame; cut < 17 stops after clock 'cut' so the next frame aborts it
  task automatic run_cycle(input int nst, input logic [3:0] pre_sc, input logic [3:0] last_sc,
                           input logic [3:0] idv, input logic [27:0] a, input logic [3:0] sz,
                           input int cut);
    bit         good;
    logic [7:0] d;
    logic       exp_oe;
    logic [3:0] exp_nib;
    int         req_base;
    good     = (last_sc == 4'b1101) && (idv == MY_ID) && (sz == 4'b0000);
    d        = mem_fn(a);
    req_base = 0;
    for (int i = 0; i < nst - 1; i++) begin
      @(negedge clk);
      frame_n = 1'b0;
      bus_i   = pre_sc;
    end
    @(negedge clk);
    frame_n = 1'b0;
    bus_i   = last_sc;
    for (int k = 2; k <= cut; k++) begin
      @(negedge clk);
      if (k == 2) req_base = req_cnt;
      exp_oe  = good && (k >= 12) && (k <= 16);
      exp_nib = (k == 13) ? 4'h0 : (k == 14) ? d[3:0] : (k == 15) ? d[7:4] : 4'hF;
      if (!good)
        chk(bus_oe == 1'b0, "R3/R5/R6 no drive on rejected frame", {31'b0, bus_oe}, 0);
      else if (k == 11)
        chk(bus_oe == 1'b0, "R7 host turnaround undriven", {31'b0, bus_oe}, 0);
      else if (k == 17)
        chk(bus_oe == 1'b0, "R9 released on clock 17", {31'b0, bus_oe}, 0);
      else
        chk(bus_oe == exp_oe, "R7/R9 enable window", {31'b0, bus_oe}, {31'b0, exp_oe});
      if (exp_oe) begin
        if (k == 12 || k == 13)
          chk(bus_o == exp_nib, "R7 turnaround/sync nibble", {28'b0, bus_o}, {28'b0, exp_nib});
        else if (k == 16)
          chk(bus_o == exp_nib, "R9 closing ones", {28'b0, bus_o}, {28'b0, exp_nib});
        else
          chk(bus_o == exp_nib, "R8 data nibble order", {28'b0, bus_o}, {28'b0, exp_nib});
      end
      if (k == 17) begin
        chk((req_cnt - req_base) == (good ? 1 : 0), "R10 request count",
            req_cnt - req_base, good ? 1 : 0);
        if (good) chk(last_addr == a, "R4 assembled address", {4'b0, last_addr}, {4'b0, a});
      end
      frame_n = 1'b1;
      if (k == 2)       bus_i = idv;
      else if (k <= 9)  bus_i = a[(9-k)*4 +: 4];
      else if (k == 10) bus_i = sz;
      else if (k == 11) bus_i = 4'hF;
      else              bus_i = 4'($urandom);
    end
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      chk(bus_oe == 1'b0, "R9 idle between frames", {31'b0, bus_oe}, 0);
      frame_n = 1'b1;
      bus_i   = 4'hF;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    int unsigned seed_init;
    int          nst, cut;
    logic [3:0]  sc, idv, sz;
    checks = 0; errors = 0; req_cnt = 0; done = 0;
    last_addr = '0; mem_rdata = '0;
    seed_init = $urandom(32'h1F2E);
    rst_n = 1'b0; frame_n = 1'b1; bus_i = 4'hF; id_strap = MY_ID;
    repeat (3) @(negedge clk);
    chk(bus_oe == 1'b0 && mem_req == 1'b0, "R1 quiet in reset", {30'b0, bus_oe, mem_req}, 0);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    chk(bus_oe == 1'b0 && mem_req == 1'b0, "R1 quiet after reset", {30'b0, bus_oe, mem_req}, 0);

    run_cycle(1, 4'h0, 4'b1101, MY_ID, 28'h1234567, 4'h0, 17); idle(1);       // R2 R4 R7 R8 R9 R10 clean
    run_cycle(1, 4'h0, 4'b1101, MY_ID, 28'h0000000, 4'h0, 17); idle(1);       // R4 zeros
    run_cycle(1, 4'h0, 4'b1101, MY_ID, 28'hFFFFFFF, 4'h0, 17); idle(1);       // R4 ones
    run_cycle(1, 4'h0, 4'b1101, 4'h3,  28'h0ABCDEF, 4'h0, 17); idle(1);       // R3 mismatch
    run_cycle(1, 4'h0, 4'b1100, MY_ID, 28'h0ABCDEF, 4'h0, 17); idle(1);       // R6 bad start
    run_cycle(1, 4'h0, 4'b1101, MY_ID, 28'h0ABCDEF, 4'h1, 17); idle(1);       // R5 bad size
    run_cycle(3, 4'h0, 4'b1101, MY_ID, 28'h7654321, 4'h0, 17); idle(1);       // R2 last start wins
    run_cycle(3, 4'b1101, 4'b0010, MY_ID, 28'h7654321, 4'h0, 17); idle(1);    // R2 R6 last not start
    run_cycle(1, 4'h0, 4'b1101, MY_ID, 28'h1111111, 4'h0, 14);                // R11 abort in data
    run_cycle(1, 4'h0, 4'b1101, MY_ID, 28'h2468ACE, 4'h0, 17); idle(1);       // R11 recovery
    run_cycle(1, 4'h0, 4'b1101, MY_ID, 28'h3333333, 4'h0, 5);                 // R11 abort in address
    run_cycle(1, 4'h0, 4'b1101, MY_ID, 28'h13579BD, 4'h0, 17); idle(1);       // R11 recovery

    for (int n = 0; n < 250; n++) begin
      nst = 1 + int'($urandom % 3);
      sc  = ($urandom % 8 != 0) ? 4'b1101 : 4'($urandom);
      idv = ($urandom % 4 != 0) ? MY_ID : 4'($urandom);
      sz  = ($urandom % 8 != 0) ? 4'h0 : 4'($urandom);
      cut = ($urandom % 6 != 0) ? 17 : 3 + int'($urandom % 14);
      run_cycle(nst, 4'($urandom), sc, idv, 28'($urandom), sz, cut);
      if (cut == 17) idle(int'($urandom % 3));
    end
    run_cycle(1, 4'h0, 4'b1101, MY_ID, 28'h0C0FFEE, 4'h0, 17); idle(2);

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule